// File: doc/BRIEF.md
# Trace Stimulus Register Front-End

This block is the software-facing register file of an instrumentation trace source. Code running on the processor writes data words to one of a set of stimulus ports. Each accepted write becomes a one-cycle push request toward an external trace FIFO. The request carries the port number and the data word. The bus side is a plain single-cycle register interface: address, write strobe, write data, combinational read data and a privilege flag that comes with every access.

A stimulus write must clear three gates before it is forwarded:
- a master enable held in the control register;
- a per-port enable mask;
- a group privilege mask, in which one bit restricts a group of eight ports to privileged code.

The configuration registers (enable mask, privilege mask and control) are guarded by a key lock. A privileged write of the key value opens them. Any other privileged value closes them again. A lock-status word reports the lock state. Reading any stimulus port returns whether the FIFO can accept data, so software can poll before it writes.

Top module: `trace_stim_regs`

## Requirements
- R1: Address map, with byte addresses: stimulus port p sits at 4*p for p in 0..31 (address bits [1:0] are ignored), the enable mask at 0xE00, the privilege mask at 0xE40, control at 0xE80, the lock key at 0xFB0 and lock status at 0xFB4. Reads of the lock key and of every unmapped address return 0.
- R2: A stimulus write to port p produces a push only if bit p of the enable mask is 1.
- R3: A read of any stimulus port returns 1 in bit 0 when fifo_full is 0, and 0 when fifo_full is 1. All other bits read 0.
- R4: Control bit 0 is the master enable. While it is 0, stimulus writes produce no push and enable-mask writes are ignored.
- R5: Privilege mask bit k (k = 0..3) covers ports 8k..8k+7. Bit value 1 means privileged access only. An unprivileged stimulus write to a restricted group is dropped. A privileged stimulus write is never blocked by the privilege mask.
- R6: An enable-mask write needs the lock open and the master enable set. A privileged write updates all 32 bits. An unprivileged write updates only byte k (bits 8k+7..8k) for each k whose privilege mask bit is 0, and leaves the other bytes unchanged.
- R7: Privilege-mask and control writes take effect only when privileged and with the lock open. Unprivileged writes to them are ignored. The privilege mask reads back as its 4 bits in [3:0], with zeros above. Control reads back all 32 bits written.
- R8: A privileged write of 0xC5ACCE55 to the lock key opens the lock. A privileged write of any other value closes it. Unprivileged lock-key writes are ignored. While the lock is closed, writes to the enable, privilege and control registers are ignored. The lock does not gate stimulus writes.
- R9: Lock status reads bit 0 = 1, bit 1 = 1 while locked, and 0 in bit 2 and in all upper bits. The lock is closed after reset, so lock status reads 0x3.
- R10: The enable mask, privilege mask and control register reset to 0.
- R11: An accepted stimulus write raises push_valid for exactly the one cycle after the write's clock edge. push_port carries the 5-bit port index and push_data carries the written word.
- R12: No push is issued for a stimulus write made while fifo_full is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 for a privileged access |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fifo_full | input | 1 | Trace FIFO cannot accept a push |
| push_valid | output | 1 | One-cycle push request |
| push_port | output | 5 | Stimulus port index of the push |
| push_data | output | 32 | Data word of the push |

## Verification
The main test writes to every one of the 32 ports, once privileged and once unprivileged. It does this under an enable mask and a privilege mask whose patterns differ between neighbouring ports and between groups. This separates the per-port enable gate from the per-group privilege gate and exposes wrong port-to-group mapping. Further scenarios hold the lock closed, clear the master enable or raise fifo_full while the other gates stay open. Each of these shows that one gate alone can block a push. Byte-lane readback after an unprivileged enable-mask write shows which groups the privilege mask protects.

// File: rtl/trace_stim_pkg.sv
`timescale 1ns/1ps
package trace_stim_pkg;
   localparam logic [11:0] OFS_ENABLE = 12'hE00;
   localparam logic [11:0] OFS_PRIV   = 12'hE40;
   localparam logic [11:0] OFS_CTRL   = 12'hE80;
   localparam logic [11:0] OFS_KEY    = 12'hFB0;
   localparam logic [11:0] OFS_STATUS = 12'hFB4;
   localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

   typedef struct packed {
      logic stim;
      logic enable;
      logic priv;
      logic ctrl;
      logic key;
      logic status;
   } reg_hit_t;
endpackage

// File: rtl/trace_stim_decode.sv
`timescale 1ns/1ps
module trace_stim_decode
   import trace_stim_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_PORTS = 32,
   parameter int PORT_W    = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit,
   output logic [PORT_W-1:0] port
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must cover the 4 KiB register window");
      end
      if (NUM_PORTS * 4 > 'hE00) begin : g_bad_ports
         $error("stimulus window overlaps configuration registers");
      end
   endgenerate

   assign word_idx = addr[ADDR_W-1:2];
   assign port     = word_idx[PORT_W-1:0];

   always_comb begin
      hit.stim   = (word_idx < IDX_W'(NUM_PORTS));
      hit.enable = (addr == ADDR_W'(OFS_ENABLE));
      hit.priv   = (addr == ADDR_W'(OFS_PRIV));
      hit.ctrl   = (addr == ADDR_W'(OFS_CTRL));
      hit.key    = (addr == ADDR_W'(OFS_KEY));
      hit.status = (addr == ADDR_W'(OFS_STATUS));
   end
endmodule

// File: rtl/trace_stim_cfg.sv
`timescale 1ns/1ps
module trace_stim_cfg
   import trace_stim_pkg::*;
#(
   parameter int NUM_PORTS  = 32,
   parameter int GROUP_SIZE = 8,
   parameter int NUM_GROUPS = 4,
   parameter int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic                  priv,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  hit_enable,
   input  logic                  hit_priv,
   input  logic                  hit_ctrl,
   input  logic                  hit_key,
   output logic [NUM_PORTS-1:0]  en_mask,
   output logic [NUM_GROUPS-1:0] prv_mask,
   output logic [DATA_W-1:0]     ctl,
   output logic                  locked
);
   logic                 cfg_open;
   logic [NUM_PORTS-1:0] en_next;

   generate
      if (DATA_W < 32 || NUM_PORTS > DATA_W) begin : g_bad_width
         $error("DATA_W must hold the key and the enable mask");
      end
   endgenerate

   assign cfg_open = wr && !locked;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
      logic lane_we;
      assign lane_we = cfg_open && hit_enable && ctl[0] && (priv || !prv_mask[g]);
      assign en_next[g*GROUP_SIZE +: GROUP_SIZE] =
         lane_we ? wdata[g*GROUP_SIZE +: GROUP_SIZE] : en_mask[g*GROUP_SIZE +: GROUP_SIZE];

      // R6: an unprivileged write never alters a restricted lane
      assert_user_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && hit_enable && !priv && prv_mask[g]) |=> $stable(en_mask[g*GROUP_SIZE +: GROUP_SIZE]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask  <= '0;
         prv_mask <= '0;
         ctl      <= '0;
         locked   <= 1'b1;
      end else begin
         en_mask <= en_next;
         if (cfg_open && priv && hit_priv) prv_mask <= wdata[NUM_GROUPS-1:0];
         if (cfg_open && priv && hit_ctrl) ctl <= wdata;
         if (wr && priv && hit_key) locked <= (wdata != DATA_W'(UNLOCK_KEY));
      end
   end

   assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(prv_mask) && $stable(ctl) && $stable(en_mask)));

   assert_user_no_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !priv && (hit_priv || hit_ctrl)) |=> ($stable(prv_mask) && $stable(ctl)));

   assert_user_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !priv && hit_key) |=> $stable(locked));
endmodule

// File: rtl/trace_stim_gate.sv
`timescale 1ns/1ps
module trace_stim_gate #(
   parameter int NUM_PORTS  = 32,
   parameter int GROUP_SIZE = 8,
   parameter int NUM_GROUPS = 4,
   parameter int PORT_W     = 5,
   parameter int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic                  priv,
   input  logic                  stim_hit,
   input  logic [PORT_W-1:0]     port,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_PORTS-1:0]  en_mask,
   input  logic [NUM_GROUPS-1:0] prv_mask,
   input  logic                  master,
   input  logic                  fifo_full,
   output logic                  push_valid,
   output logic [PORT_W-1:0]     push_port,
   output logic [DATA_W-1:0]     push_data
);
   logic [NUM_PORTS-1:0] port_open;
   logic                 accept;

   generate
      if (NUM_GROUPS * GROUP_SIZE != NUM_PORTS) begin : g_bad_groups
         $error("ports must split evenly into privilege groups");
      end
      if ((1 << PORT_W) < NUM_PORTS) begin : g_bad_port_w
         $error("PORT_W too narrow for NUM_PORTS");
      end
   endgenerate

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_open[p] = en_mask[p] && (priv || !prv_mask[p / GROUP_SIZE]);
   end

   assign accept = wr && stim_hit && master && !fifo_full && port_open[port];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_valid <= 1'b0;
         push_port  <= '0;
         push_data  <= '0;
      end else begin
         push_valid <= accept;
         if (accept) begin
            push_port <= port;
            push_data <= wdata;
         end
      end
   end

   assert_push_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> $past(master));

   assert_push_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> !$past(fifo_full));

   assert_push_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> $past(en_mask[port]));

   assert_push_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> ($past(wr) && $past(stim_hit)));
endmodule

// File: rtl/trace_stim_regs.sv
`timescale 1ns/1ps
module trace_stim_regs
   import trace_stim_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NUM_PORTS  = 32,
   parameter int GROUP_SIZE = 8,
   localparam int NUM_GROUPS = NUM_PORTS / GROUP_SIZE,
   localparam int PORT_W     = $clog2(NUM_PORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              fifo_full,
   output logic              push_valid,
   output logic [PORT_W-1:0] push_port,
   output logic [DATA_W-1:0] push_data
);
   reg_hit_t              hit;
   logic [PORT_W-1:0]     dec_port;
   logic [NUM_PORTS-1:0]  en_mask;
   logic [NUM_GROUPS-1:0] prv_mask;
   logic [DATA_W-1:0]     ctl;
   logic                  locked;

   trace_stim_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_decode (
      .addr(bus_addr), .hit(hit), .port(dec_port)
   );

   trace_stim_cfg #(.NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE),
                    .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .priv(bus_priv), .wdata(bus_wdata),
      .hit_enable(hit.enable), .hit_priv(hit.priv), .hit_ctrl(hit.ctrl), .hit_key(hit.key),
      .en_mask(en_mask), .prv_mask(prv_mask), .ctl(ctl), .locked(locked)
   );

   trace_stim_gate #(.NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS),
                     .PORT_W(PORT_W), .DATA_W(DATA_W)) i_gate (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .priv(bus_priv), .stim_hit(hit.stim),
      .port(dec_port), .wdata(bus_wdata), .en_mask(en_mask), .prv_mask(prv_mask),
      .master(ctl[0]), .fifo_full(fifo_full),
      .push_valid(push_valid), .push_port(push_port), .push_data(push_data)
   );

   // R1 read multiplexer; the lock key is write-only and reads zero
   always_comb begin
      bus_rdata = '0;
      if (hit.stim)        bus_rdata = DATA_W'(!fifo_full);
      else if (hit.enable) bus_rdata = DATA_W'(en_mask);
      else if (hit.priv)   bus_rdata = DATA_W'(prv_mask);
      else if (hit.ctrl)   bus_rdata = ctl;
      else if (hit.status) bus_rdata = DATA_W'({1'b0, locked, 1'b1});
   end

   assert_status_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit.status |-> (bus_rdata[0] && !bus_rdata[2]));
endmodule

// File: tb/test_trace_stim_regs.sv
`timescale 1ns/1ps
module test_trace_stim_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_priv = 1'b0;
   logic [31:0] bus_rdata;
   logic        fifo_full = 1'b0;
   logic        push_valid;
   logic [4:0]  push_port;
   logic [31:0] push_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic        got_v;
   logic [4:0]  got_port;
   logic [31:0] got_data;
   logic [31:0] rd;

   logic [31:0] en_m;
   logic [3:0]  pm_m;

   always #10 clk = ~clk;

   trace_stim_regs i_trace_stim_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
      .fifo_full(fifo_full), .push_valid(push_valid), .push_port(push_port),
      .push_data(push_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [11:0] a, input logic [31:0] d, input logic p);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      got_v = push_valid; got_port = push_port; got_data = push_data;
   endtask

   task automatic bread(input logic [11:0] a);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1 rd = bus_rdata;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      bread(12'hE00); check("R10 enable reset", rd, 32'h0);
      bread(12'hE40); check("R10 priv reset", rd, 32'h0);
      bread(12'hE80); check("R10 ctrl reset", rd, 32'h0);
      bread(12'hFB4); check("R9 status reset", rd, 32'h3);
      bread(12'hFB0); check("R1 key reads zero", rd, 32'h0);
      bread(12'h080); check("R1 past stimulus window", rd, 32'h0);
      bread(12'h100); check("R1 unmapped", rd, 32'h0);

      // locked: control write ignored
      bwrite(12'hE80, 32'h1, 1'b1);
      bread(12'hE80); check("R8 ctrl write while locked", rd, 32'h0);
      bwrite(12'hFB0, 32'hC5ACCE55, 1'b0);
      bread(12'hFB4); check("R8 unprivileged key ignored", rd, 32'h3);
      bwrite(12'hFB0, 32'hC5ACCE55, 1'b1);
      bread(12'hFB4); check("R9 status unlocked", rd, 32'h1);

      // master clear
      bwrite(12'hE00, 32'hFFFF_FFFF, 1'b1);
      bread(12'hE00); check("R4 enable write without master", rd, 32'h0);
      bwrite(12'h000, 32'h1234, 1'b1);
      check("R4 no push without master", {31'b0, got_v}, 32'h0);

      // control and privilege write rules
      bwrite(12'hE80, 32'h1, 1'b0);
      bread(12'hE80); check("R7 unprivileged ctrl ignored", rd, 32'h0);
      bwrite(12'hE80, 32'h0000_0301, 1'b1);
      bread(12'hE80); check("R7 ctrl readback", rd, 32'h0000_0301);
      bwrite(12'hE40, 32'hF, 1'b0);
      bread(12'hE40); check("R7 unprivileged priv ignored", rd, 32'h0);
      bwrite(12'hE40, 32'hFFFF_FFF5, 1'b1);
      bread(12'hE40); check("R7 priv readback low bits", rd, 32'h5);
      pm_m = 4'h5;

      // enable lanes under privilege mask
      bwrite(12'hE00, 32'hFFFF_FFFF, 1'b0);
      bread(12'hE00); check("R6 unprivileged lane update", rd, 32'hFF00_FF00);
      bwrite(12'hE00, 32'hA5C3_3C5A, 1'b1);
      bread(12'hE00); check("R6 privileged full update", rd, 32'hA5C3_3C5A);
      en_m = 32'hA5C3_3C5A;

      // sweep: every port, both privilege levels
      for (int p = 0; p < 32; p++) begin
         for (int pv = 0; pv < 2; pv++) begin
            logic exp_v;
            logic [31:0] d;
            d = 32'h1000_0000 | (p << 8) | pv;
            exp_v = en_m[p] && (pv == 1 || !pm_m[p / 8]);
            bwrite(12'(p * 4), d, pv[0]);
            check(en_m[p] ? "R5 privilege gate" : "R2 enable gate", {31'b0, got_v}, {31'b0, exp_v});
            if (exp_v) begin
               check("R11 push port", {27'b0, got_port}, p);
               check("R11 push data", got_data, d);
            end
         end
      end

      // pulse width
      bwrite(12'h004, 32'hCAFE_0001, 1'b1);
      check("R11 push raised", {31'b0, got_v}, 32'h1);
      @(negedge clk);
      check("R11 push single cycle", {31'b0, push_valid}, 32'h0);

      // FIFO full
      fifo_full = 1'b1;
      bread(12'h014); check("R3 stimulus read full", rd, 32'h0);
      bwrite(12'h004, 32'h55, 1'b1);
      check("R12 no push when full", {31'b0, got_v}, 32'h0);
      fifo_full = 1'b0;
      bread(12'h07C); check("R3 stimulus read not full", rd, 32'h1);
      bread(12'h07E); check("R1 low address bits ignored", rd, 32'h1);

      // wrong key relocks, stimulus unaffected by lock
      bwrite(12'hFB0, 32'h1234_5678, 1'b1);
      bread(12'hFB4); check("R8 wrong key relocks", rd, 32'h3);
      bwrite(12'hE80, 32'h0, 1'b1);
      bread(12'hE80); check("R8 ctrl held while relocked", rd, 32'h0000_0301);
      bwrite(12'h004, 32'h77, 1'b1);
      check("R8 lock does not gate stimulus", {31'b0, got_v}, 32'h1);

      // master off again
      bwrite(12'hFB0, 32'hC5ACCE55, 1'b1);
      bwrite(12'hE80, 32'h0, 1'b1);
      bwrite(12'h004, 32'h88, 1'b1);
      check("R4 master cleared blocks push", {31'b0, got_v}, 32'h0);
      bwrite(12'hE00, 32'h0, 1'b1);
      bread(12'hE00); check("R4 enable held without master", rd, 32'hA5C3_3C5A);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule